// File: doc/BRIEF.md
# Handset Power Sequencing Controller

This synchronous controller decides which supply rails of a handset power unit are switched on. It takes only clean, already-debounced logic flags:
- a power key (active low);
- a power-hold level from the processor;
- charger presence, plus TCXO-supply and SIM-supply requests;
- a power-good flag from the core rail;
- three battery comparator flags (above 3.2 V, above 3.0 V, above 2.4 V);
- two die-temperature flags (hot above 160 °C, cool below 125 °C).

From these it drives enables for six rails (core, memory, analog, TCXO, SIM, RTC), a key-status level for the processor to poll, an enable for the battery sense divider, and an active-low system reset. The reset is released a programmable number of cycles after the core rail is good.

The system can be woken by a key press, by the processor's hold level, or by a charger. A battery start check with hysteresis gates start-up and is ignored once the system is running. Two conditions override every power request. A deep-discharge flag switches everything off, the RTC rail included. A thermal latch switches everything off except the RTC rail until the die reports cool.

Every rail, divider and key-status output is registered, so each responds on the first clock edge after its inputs change.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: With the system able to start, a low `key_n` or a high `chg_det` enables the core, memory, analog and TCXO rails one cycle later, and keeps them on while that source stays active. These two sources never enable the SIM rail.
- R2: With the system able to start, `hold_in` alone enables only the core and memory rails. The rails drop one cycle after the last active source goes away.
- R3: `key_stat_n` equals `key_n` delayed by one cycle, and is 1 in reset.
- R4: While the system is on, a high `tcxo_req` enables the analog and TCXO rails together.
- R5: `en_sim` follows `sim_req` one cycle later, whether the system is on or off. It is blocked only by the thermal latch or by deep discharge.
- R6: `sys_rst_n` is low in reset and while the core rail is off. It rises exactly `rst_dly`+1 cycles after the first edge on which `en_core` and `core_pg` are both high.
- R7: The system can start only when the battery is above the 3.2 V flag (`bat_hi`). After any cycle in which a start was allowed, the start level drops to the 3.0 V flag (`bat_mid`). The lower level is lost as soon as `bat_mid` is seen low while no start is allowed.
- R8: While the system is on, low `bat_hi` or `bat_mid` flags have no effect on the rails.
- R9: When `bat_lo` (above 2.4 V) is low, every rail, the RTC rail included, is off one cycle later. The RTC rail comes back one cycle after `bat_lo` returns.
- R10: A high `die_hot` switches off every rail except RTC one cycle later. The rails stay off until `die_cool` is seen high with `die_hot` low, whatever the power sources do.
- R11: `div_en` is high only while the system is on with both `hold_in` and `tcxo_req` high.
- R12: After reset, `en_rtc` is 1 and every other rail enable is 0.
- R13: If `core_pg` falls before the delay expires, or at any later time, reset goes low on the next edge. The delay count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_n | input | 1 | Power key, low when pressed |
| hold_in | input | 1 | Processor power-hold level |
| chg_det | input | 1 | Charger detected |
| tcxo_req | input | 1 | Request for the analog and TCXO rails |
| sim_req | input | 1 | Request for the SIM rail |
| core_pg | input | 1 | Core rail power-good |
| bat_hi | input | 1 | Battery above 3.2 V |
| bat_mid | input | 1 | Battery above 3.0 V |
| bat_lo | input | 1 | Battery above 2.4 V |
| die_hot | input | 1 | Die above 160 °C |
| die_cool | input | 1 | Die below 125 °C |
| rst_dly | input | CNT_W | Reset delay in cycles |
| en_core | output | 1 | Core rail enable |
| en_mem | output | 1 | Memory rail enable |
| en_ana | output | 1 | Analog rail enable |
| en_tcxo | output | 1 | TCXO rail enable |
| en_sim | output | 1 | SIM rail enable |
| en_rtc | output | 1 | RTC rail enable |
| div_en | output | 1 | Battery divider enable |
| key_stat_n | output | 1 | Key status, low while pressed |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
Every rail, divider and key-status result is due one clock edge after its inputs change. The bench therefore drives each table row on a falling edge and samples one falling edge later, so exactly one rising edge lies between stimulus and check.

The reset output counts both registers on its path. `en_core` needs one edge, and the delay counter then needs `rst_dly`+1 edges with power-good high. The bench samples just before and just after the predicted rising edge, both from a cold start and after a power-good dropout.

The table carries rail state from row to row, so the hysteresis, thermal latch and deep-discharge rows are checked in the order that sets them up.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef struct packed {
    logic core;
    logic mem;
    logic ana;
    logic tcxo;
    logic sim;
    logic rtc;
    logic div;
  } rails_t;

  localparam rails_t RAILS_RST = rails_t'(7'b0000010);

  // Start level with hysteresis: 3.2 V before arming, 3.0 V after.
  function automatic logic start_allowed(input logic armed, input logic hi, input logic mid);
    return hi | (armed & mid);
  endfunction

  // Thermal latch: set by hot, released only by cool.
  function automatic logic therm_block(input logic held, input logic hot, input logic cool);
    return hot | (held & ~cool);
  endfunction

  // Rail selection for a given on-state and set of requests.
  function automatic rails_t rail_map(input logic on, input logic big_src, input logic hold,
                                      input logic tcxo, input logic sim_ok, input logic rtc_ok);
    rails_t r;
    r.core = on & (big_src | hold);
    r.mem  = on & (big_src | hold);
    r.ana  = on & (big_src | tcxo);
    r.tcxo = on & (big_src | tcxo);
    r.sim  = sim_ok;
    r.rtc  = rtc_ok;
    r.div  = on & hold & tcxo;
    return r;
  endfunction

  function automatic logic dly_expired(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt == lim;
  endfunction

endpackage

// File: rtl/pwr_guard.sv
module pwr_guard
  import pwr_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bat_hi,
  input  logic bat_mid,
  input  logic die_hot,
  input  logic die_cool,
  output logic start_ok,
  output logic blk_nx
);
  logic armed_q;
  logic therm_q;

  assign start_ok = start_allowed(armed_q, bat_hi, bat_mid);
  assign blk_nx   = therm_block(therm_q, die_hot, die_cool);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      therm_q <= 1'b0;
    end else begin
      armed_q <= start_ok;
      therm_q <= blk_nx;
    end
  end

  // R7: with neither the 3.2 V nor the 3.0 V flag set, no start is allowed
  a_r7_no_start_low_batt: assert property (@(posedge clk) disable iff (!rst_n)
    (!bat_hi && !bat_mid) |-> !start_ok);

  // R10: while latched, the block is released only by the cool flag
  a_r10_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (die_hot) |=> (die_cool || blk_nx));
endmodule

// File: rtl/pwr_rail_ctl.sv
module pwr_rail_ctl
  import pwr_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   key_n,
  input  logic   hold_in,
  input  logic   chg_det,
  input  logic   tcxo_req,
  input  logic   sim_req,
  input  logic   bat_lo,
  input  logic   start_ok,
  input  logic   blk_nx,
  output rails_t rails,
  output logic   sys_on
);
  logic   big_src;
  logic   any_src;
  logic   on_nx;
  rails_t rails_nx;

  assign big_src  = ~key_n | chg_det;
  assign any_src  = big_src | hold_in;
  assign on_nx    = ~blk_nx & bat_lo & any_src & (sys_on | start_ok);
  assign rails_nx = rail_map(on_nx, big_src, hold_in, tcxo_req,
                             sim_req & ~blk_nx & bat_lo, bat_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rails  <= RAILS_RST;
      sys_on <= 1'b0;
    end else begin
      rails  <= rails_nx;
      sys_on <= on_nx;
    end
  end

  // R2: with no source active, the system is off next cycle
  a_r2_drop_no_src: assert property (@(posedge clk) disable iff (!rst_n)
    (key_n && !hold_in && !chg_det) |=> !sys_on);

  // R5: SIM tracks its request when no protection is active
  a_r5_sim_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (bat_lo && !blk_nx) |=> (rails.sim == $past(sim_req)));
endmodule

// File: rtl/pwr_rst_tmr.sv
module pwr_rst_tmr
  import pwr_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_on,
  input  logic             core_pg,
  input  logic [CNT_W-1:0] dly,
  output logic             rst_out_n
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             pg_ok;
  logic             expire;

  assign pg_ok     = core_on & core_pg;
  assign expire    = dly_expired(32'(cnt_q), 32'(dly));
  assign rst_out_n = done_q & core_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!pg_ok) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (expire) done_q <= 1'b1;
      else        cnt_q  <= cnt_q + ONE;
    end
  end

  // R13: loss of power-good clears the release on the next edge
  a_r13_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_ok |=> !done_q);

  // R6: release only ever follows a cycle with good power
  a_r6_release_needs_pg: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(pg_ok));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_n,
  input  logic             hold_in,
  input  logic             chg_det,
  input  logic             tcxo_req,
  input  logic             sim_req,
  input  logic             core_pg,
  input  logic             bat_hi,
  input  logic             bat_mid,
  input  logic             bat_lo,
  input  logic             die_hot,
  input  logic             die_cool,
  input  logic [CNT_W-1:0] rst_dly,
  output logic             en_core,
  output logic             en_mem,
  output logic             en_ana,
  output logic             en_tcxo,
  output logic             en_sim,
  output logic             en_rtc,
  output logic             div_en,
  output logic             key_stat_n,
  output logic             sys_rst_n
);
  logic   start_ok;
  logic   blk_nx;
  logic   sys_on;
  rails_t rails;

  pwr_guard u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .bat_hi   (bat_hi),
    .bat_mid  (bat_mid),
    .die_hot  (die_hot),
    .die_cool (die_cool),
    .start_ok (start_ok),
    .blk_nx   (blk_nx)
  );

  pwr_rail_ctl u_rails (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_n    (key_n),
    .hold_in  (hold_in),
    .chg_det  (chg_det),
    .tcxo_req (tcxo_req),
    .sim_req  (sim_req),
    .bat_lo   (bat_lo),
    .start_ok (start_ok),
    .blk_nx   (blk_nx),
    .rails    (rails),
    .sys_on   (sys_on)
  );

  pwr_rst_tmr #(.CNT_W(CNT_W)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .core_on   (rails.core),
    .core_pg   (core_pg),
    .dly       (rst_dly),
    .rst_out_n (sys_rst_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_stat_n <= 1'b1;
    else        key_stat_n <= key_n;
  end

  assign en_core = rails.core;
  assign en_mem  = rails.mem;
  assign en_ana  = rails.ana;
  assign en_tcxo = rails.tcxo;
  assign en_sim  = rails.sim;
  assign en_rtc  = rails.rtc;
  assign div_en  = rails.div;

  // R1: key press with a full battery and no protection turns on the four main rails
  a_r1_key_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_n && bat_hi && bat_lo && !die_hot && die_cool)
      |=> (en_core && en_mem && en_ana && en_tcxo));

  // R3: key status is the key level one cycle late
  a_r3_key_stat: assert property (@(posedge clk) disable iff (!rst_n)
    !key_n |=> !key_stat_n);

  // R8: undervoltage flags are ignored while the system is held on
  a_r8_uv_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (en_core && hold_in && bat_lo && !die_hot && die_cool) |=> en_core);

  // R9: deep discharge clears every rail
  a_r9_deep_dis: assert property (@(posedge clk) disable iff (!rst_n)
    !bat_lo |=> (!en_rtc && !en_core && !en_sim && !en_ana));

  // R10: hot die clears every rail except RTC
  a_r10_hot_off: assert property (@(posedge clk) disable iff (!rst_n)
    die_hot |=> (!en_core && !en_mem && !en_ana && !en_tcxo && !en_sim));

  // R11: divider implies the rails it measures through are up
  a_r11_div: assert property (@(posedge clk) disable iff (!rst_n)
    div_en |-> (en_core && en_ana));

  // R6: reset is never released with the core rail off
  a_r6_core_off_rst: assert property (@(posedge clk) disable iff (!rst_n)
    !en_core |-> !sys_rst_n);
endmodule

// File: tb/pwr_seq_ctrl_tb.sv
module pwr_seq_ctrl_tb;
  localparam int CNT_W = 16;
  localparam int DLY   = 5;
  localparam int NVEC  = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_n = 1'b1, hold_in = 1'b0, chg_det = 1'b0, tcxo_req = 1'b0, sim_req = 1'b0;
  logic core_pg = 1'b0, bat_hi = 1'b1, bat_mid = 1'b1, bat_lo = 1'b1;
  logic die_hot = 1'b0, die_cool = 1'b1;
  logic [CNT_W-1:0] rst_dly = CNT_W'(DLY);
  logic en_core, en_mem, en_ana, en_tcxo, en_sim, en_rtc, div_en, key_stat_n, sys_rst_n;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pwr_seq_ctrl #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .key_n(key_n), .hold_in(hold_in), .chg_det(chg_det),
    .tcxo_req(tcxo_req), .sim_req(sim_req), .core_pg(core_pg), .bat_hi(bat_hi),
    .bat_mid(bat_mid), .bat_lo(bat_lo), .die_hot(die_hot), .die_cool(die_cool),
    .rst_dly(rst_dly), .en_core(en_core), .en_mem(en_mem), .en_ana(en_ana),
    .en_tcxo(en_tcxo), .en_sim(en_sim), .en_rtc(en_rtc), .div_en(div_en),
    .key_stat_n(key_stat_n), .sys_rst_n(sys_rst_n)
  );

  // Row: inputs {key_n,hold,chg,tcxo,sim,hi,mid,lo,hot,cool} _ expected {core,mem,ana,tcxo,sim,rtc,div}
  localparam logic [16:0] VEC [NVEC] = '{
    17'b1000011101_0000010,  // idle, full battery (R12 state kept)
    17'b0000011101_1111010,  // R1 key start
    17'b0100011101_1111010,  // R1 key + hold, no divider
    17'b1100011101_1100010,  // R2 hold only
    17'b1101011101_1111011,  // R4 R11 hold + tcxo
    17'b1101111101_1111111,  // R5 sim on
    17'b1101100101_1111111,  // R8 battery below 3.0 while running
    17'b1101100001_0000000,  // R9 deep discharge
    17'b0000001101_0000010,  // R7 3.1 V after lockout: no start
    17'b0000011101_1111010,  // R7 3.3 V start
    17'b0000111110_0000010,  // R10 hot
    17'b0000111100_0000010,  // R10 not yet cool
    17'b0000111101_1111110,  // R10 cool, restart with sim
    17'b1010011101_1111010,  // R1 charger keeps rails
    17'b1000011101_0000010,  // R2 all sources gone
    17'b1000111101_0000110,  // R5 sim while off
    17'b0000001101_1111010,  // R7 hysteresis: 3.1 V starts when armed
    17'b1000001101_0000010   // R2 off
  };

  task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] rails_now();
    return {en_core, en_mem, en_ana, en_tcxo, en_sim, en_rtc, div_en};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state, R3 and R6 reset values
    chk("R12 reset rails", rails_now(), 7'b0000010);
    chk("R6 reset low", {6'b0, sys_rst_n}, 7'b0);
    chk("R3 key status reset", {6'b0, key_stat_n}, 7'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 rails after reset", rails_now(), 7'b0000010);

    for (int i = 0; i < NVEC; i++) begin
      {key_n, hold_in, chg_det, tcxo_req, sim_req, bat_hi, bat_mid, bat_lo, die_hot, die_cool}
        = VEC[i][16:7];
      @(negedge clk);
      chk($sformatf("vector %0d rails", i), rails_now(), VEC[i][6:0]);
      chk($sformatf("R3 vector %0d key status", i), {6'b0, key_stat_n}, {6'b0, VEC[i][16]});
      chk($sformatf("R6 vector %0d reset low (no pg)", i), {6'b0, sys_rst_n}, 7'b0);
    end

    // R6 delay: press key with power-good high
    {bat_hi, bat_mid, bat_lo} = 3'b111;
    key_n = 1'b0; core_pg = 1'b1;
    repeat (DLY + 1) @(negedge clk);
    chk("R6 still in reset one cycle before expiry", {6'b0, sys_rst_n}, 7'b0);
    @(negedge clk);
    chk("R6 reset released", {6'b0, sys_rst_n}, 7'b1);

    // R13 dropout restarts the count
    core_pg = 1'b0;
    @(negedge clk);
    chk("R13 reset after pg loss", {6'b0, sys_rst_n}, 7'b0);
    core_pg = 1'b1;
    repeat (DLY) @(negedge clk);
    chk("R13 count restarted, still low", {6'b0, sys_rst_n}, 7'b0);
    @(negedge clk);
    chk("R13 released after full recount", {6'b0, sys_rst_n}, 7'b1);

    // R6 power-off pulls reset low with the core rail
    key_n = 1'b1;
    @(negedge clk);
    chk("R6 reset low at power-off", {6'b0, sys_rst_n}, 7'b0);
    chk("R2 rails off at power-off", rails_now(), 7'b0000010);

    finish_run();
  end
endmodule